// File: doc/BRIEF.md
# Multimode CHR Address Composer

This block builds the upper pattern-memory address bits, A20 down to A10, for a cartridge bank controller that can behave in three ways. It holds an 8-bit outer CHR base register and a small CHR latch. On every access it combines those two registers, the 1 KiB bank number from the inner bank-switching core, and the PPU address bits A12..A10. Three mode bits pick the way they are combined: the inner core can supply the low bits (banked mode), the latch can supply one or two bits above a PPU-driven 8 KiB page (latched mode), or the base register alone can select a fixed 8 KiB page (fixed mode).

The CPU loads the base register through a decoded write strobe. It loads the latch with any write whose address bit A15 is high, which covers the range $8000-$FFFF. A base-register write always clears the latch, so software that moves the outer window starts at inner page zero. The address output is combinational from the inputs and the two registers. When the latch is built out by a parameter, the same mode bit that would have disabled the latch instead drives a select between CHR-ROM and CHR-RAM.

Top module: `chr_addr_composer`

## Requirements
- R1: After reset the base register and the latch are both zero. In banked mode with the 256 KiB window the output is therefore {3'b000, core_bank}, and in any mode with mode_src_ppu=1 it is {8'h00, ppu_a}.
- R2: Banked mode (mode_src_ppu=0) with mode_win_small=0 gives the output {base[7:5], core_bank[7:0]}, and ppu_a has no effect.
- R3: Banked mode with mode_win_small=1 gives the output {base[7:4], core_bank[6:0]}.
- R4: Latched mode (mode_src_ppu=1, mode_b5=0, latch present) with mode_win_small=0 gives the output {base[7:2], latch[1:0], ppu_a[2:0]}.
- R5: Latched mode with mode_win_small=1 gives the output {base[7:1], latch[0], ppu_a[2:0]}. Base bit 0 is not used.
- R6: Fixed mode (mode_src_ppu=1 and mode_b5=1) gives the output {base[7:0], ppu_a[2:0]} whatever mode_win_small is.
- R7: A cycle with cpu_we=1 and cpu_a15=1 loads the latch with cpu_d[1:0], which is visible from the next cycle. A write with cpu_a15=0 leaves the latch unchanged, and cpu_d[7:2] are ignored.
- R8: A cycle with base_we=1 loads the base register with cpu_d and clears the latch to 0 in the same edge. A base write takes priority over a latch write in the same cycle.
- R9: With HAS_LATCH=0, mode_src_ppu=1 always selects fixed mode and chr_ram_sel equals mode_b5. With HAS_LATCH=1, chr_ram_sel is 0.
- R10: chr_a follows changes of ppu_a, core_bank and the mode bits within the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode_src_ppu | input | 1 | 0: low CHR bits come from the inner core; 1: they come from the PPU |
| mode_b5 | input | 1 | With mode_src_ppu=1: 0 enables the latch, 1 selects the fixed page; with no latch it selects ROM or RAM |
| mode_win_small | input | 1 | Selects the smaller outer window (128 KiB banked, 16 KiB latched) |
| ppu_a | input | 3 | PPU address A12..A10 |
| core_bank | input | 8 | 1 KiB bank number from the inner core |
| cpu_we | input | 1 | CPU write strobe |
| cpu_a15 | input | 1 | CPU address bit A15 |
| cpu_d | input | 8 | CPU write data |
| base_we | input | 1 | Decoded write strobe for the CHR base register |
| chr_a | output | 11 | CHR address A20..A10 |
| chr_ram_sel | output | 1 | 1 selects CHR-RAM (only used when no latch is built) |

## Verification
On every cycle the assertions check that the PPU bits pass through whenever the PPU is the source, and that the core bank passes through in banked mode. They also check that a base write leaves the latch field zero and that a latch write appears one cycle later in the 32 KiB latched window, and they check chr_ram_sel against the mode bit. The position of the base bits in each window, the hidden base bit in the 16 KiB window, the reset values, the writes that must be ignored and the behaviour of a build without the latch can only be shown by the bench's scenarios, which compare full address values.

// File: rtl/chr_comp_pkg.sv
package chr_comp_pkg;

  typedef enum logic [1:0] {
    CHR_BANKED  = 2'd0,
    CHR_LATCHED = 2'd1,
    CHR_FIXED   = 2'd2
  } chr_mode_e;

endpackage

// File: rtl/chr_mode_dec.sv
module chr_mode_dec
  import chr_comp_pkg::*;
#(
  parameter bit HAS_LATCH = 1'b1
) (
  input  logic      src_ppu,
  input  logic      b5,
  output chr_mode_e mode,
  output logic      ram_sel
);

  generate
    if (HAS_LATCH) begin : g_with_latch
      always_comb begin
        if (!src_ppu)  mode = CHR_BANKED;
        else if (!b5)  mode = CHR_LATCHED;
        else           mode = CHR_FIXED;
      end
      assign ram_sel = 1'b0;
    end else begin : g_no_latch
      always_comb begin
        if (!src_ppu)  mode = CHR_BANKED;
        else           mode = CHR_FIXED;
      end
      assign ram_sel = b5;
    end
  endgenerate

endmodule

// File: rtl/chr_state_regs.sv
module chr_state_regs #(
  parameter int  BASE_W    = 8,
  parameter int  LATCH_W   = 2,
  parameter bit  HAS_LATCH = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               base_we,
  input  logic               latch_we,
  input  logic [BASE_W-1:0]  din,
  output logic [BASE_W-1:0]  base_q,
  output logic [LATCH_W-1:0] latch_q
);

  logic [BASE_W-1:0] base_d;
  logic              base_en;

  // Base register: next-state and enable
  always_comb begin
    base_en = base_we;
    base_d  = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_en) base_q <= base_d;
  end

  generate
    if (HAS_LATCH) begin : g_latch
      logic [LATCH_W-1:0] latch_d;
      logic               latch_en;

      // A base write clears the latch and wins over a latch load
      always_comb begin
        latch_en = base_we | latch_we;
        if (base_we) latch_d = '0;
        else         latch_d = din[LATCH_W-1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        latch_q <= '0;
        else if (latch_en) latch_q <= latch_d;
      end
    end else begin : g_no_latch
      assign latch_q = '0;
    end
  endgenerate

endmodule

// File: rtl/chr_addr_mux.sv
module chr_addr_mux
  import chr_comp_pkg::*;
#(
  parameter int BASE_W  = 8,
  parameter int BANK_W  = 8,
  parameter int LATCH_W = 2,
  parameter int PPU_W   = 3,
  localparam int OUT_W  = BASE_W + PPU_W
) (
  input  chr_mode_e          mode,
  input  logic               win_small,
  input  logic [BASE_W-1:0]  base,
  input  logic [BANK_W-1:0]  core_bank,
  input  logic [LATCH_W-1:0] latch,
  input  logic [PPU_W-1:0]   ppu_a,
  output logic [OUT_W-1:0]   chr_a
);

  localparam logic [OUT_W-1:0] PPU_MASK =
    {{BASE_W{1'b0}}, {PPU_W{1'b1}}};
  localparam logic [OUT_W-1:0] BANK_MASK_BIG =
    {{(OUT_W-BANK_W){1'b0}}, {BANK_W{1'b1}}};
  localparam logic [OUT_W-1:0] BANK_MASK_SMALL = BANK_MASK_BIG >> 1;
  localparam logic [OUT_W-1:0] LAT_MASK_BIG =
    {{(OUT_W-LATCH_W-PPU_W){1'b0}}, {LATCH_W{1'b1}}, {PPU_W{1'b0}}};
  localparam logic [OUT_W-1:0] LAT_MASK_SMALL = (LAT_MASK_BIG >> 1) & ~PPU_MASK;

  logic [OUT_W-1:0] base_x;
  logic [OUT_W-1:0] core_x;
  logic [OUT_W-1:0] latch_x;
  logic [OUT_W-1:0] ppu_x;
  logic [OUT_W-1:0] bank_mask;
  logic [OUT_W-1:0] lat_mask;

  always_comb begin
    base_x    = {base, {PPU_W{1'b0}}};
    core_x    = {{(OUT_W-BANK_W){1'b0}}, core_bank};
    latch_x   = {{(OUT_W-LATCH_W-PPU_W){1'b0}}, latch, {PPU_W{1'b0}}};
    ppu_x     = {{BASE_W{1'b0}}, ppu_a};
    bank_mask = win_small ? BANK_MASK_SMALL : BANK_MASK_BIG;
    lat_mask  = win_small ? LAT_MASK_SMALL  : LAT_MASK_BIG;

    unique case (mode)
      CHR_BANKED:  chr_a = (base_x & ~bank_mask) | (core_x & bank_mask);
      CHR_LATCHED: chr_a = (base_x & ~lat_mask & ~PPU_MASK)
                         | (latch_x & lat_mask) | ppu_x;
      default:     chr_a = base_x | ppu_x;
    endcase
  end

endmodule

// File: rtl/chr_addr_composer.sv
module chr_addr_composer
  import chr_comp_pkg::*;
#(
  parameter int  BASE_W    = 8,
  parameter int  BANK_W    = 8,
  parameter int  LATCH_W   = 2,
  parameter int  PPU_W     = 3,
  parameter bit  HAS_LATCH = 1'b1,
  localparam int OUT_W     = BASE_W + PPU_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_src_ppu,
  input  logic              mode_b5,
  input  logic              mode_win_small,
  input  logic [PPU_W-1:0]  ppu_a,
  input  logic [BANK_W-1:0] core_bank,
  input  logic              cpu_we,
  input  logic              cpu_a15,
  input  logic [BASE_W-1:0] cpu_d,
  input  logic              base_we,
  output logic [OUT_W-1:0]  chr_a,
  output logic              chr_ram_sel
);

  logic [1:0]         rst_sync_q;
  logic               rst_core_n;
  logic               latch_we;
  logic               base_we_q;
  logic [BASE_W-1:0]  base_q;
  logic [LATCH_W-1:0] latch_q;
  chr_mode_e          mode;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  always_comb begin
    base_we_q = base_we;
    latch_we  = cpu_we & cpu_a15;
  end

  chr_mode_dec #(.HAS_LATCH(HAS_LATCH)) u_dec (
    .src_ppu (mode_src_ppu),
    .b5      (mode_b5),
    .mode    (mode),
    .ram_sel (chr_ram_sel)
  );

  chr_state_regs #(
    .BASE_W    (BASE_W),
    .LATCH_W   (LATCH_W),
    .HAS_LATCH (HAS_LATCH)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .base_we  (base_we_q),
    .latch_we (latch_we),
    .din      (cpu_d),
    .base_q   (base_q),
    .latch_q  (latch_q)
  );

  chr_addr_mux #(
    .BASE_W  (BASE_W),
    .BANK_W  (BANK_W),
    .LATCH_W (LATCH_W),
    .PPU_W   (PPU_W)
  ) u_mux (
    .mode      (mode),
    .win_small (mode_win_small),
    .base      (base_q),
    .core_bank (core_bank),
    .latch     (latch_q),
    .ppu_a     (ppu_a),
    .chr_a     (chr_a)
  );

endmodule

// File: rtl/chr_addr_composer_chk.sv
module chr_addr_composer_chk #(
  parameter int  BASE_W    = 8,
  parameter int  BANK_W    = 8,
  parameter int  LATCH_W   = 2,
  parameter int  PPU_W     = 3,
  parameter bit  HAS_LATCH = 1'b1,
  localparam int OUT_W     = BASE_W + PPU_W
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              mode_src_ppu,
  input logic              mode_b5,
  input logic              mode_win_small,
  input logic [PPU_W-1:0]  ppu_a,
  input logic [BANK_W-1:0] core_bank,
  input logic              cpu_we,
  input logic              cpu_a15,
  input logic [BASE_W-1:0] cpu_d,
  input logic              base_we,
  input logic [OUT_W-1:0]  chr_a,
  input logic              chr_ram_sel
);

  logic lat_big;
  assign lat_big = HAS_LATCH && mode_src_ppu && !mode_b5 && !mode_win_small;

  // R6
  ppu_pass_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    mode_src_ppu |-> chr_a[PPU_W-1:0] == ppu_a);

  // R2
  bank_big_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!mode_src_ppu && !mode_win_small) |-> chr_a[BANK_W-1:0] == core_bank);

  // R3
  bank_small_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!mode_src_ppu && mode_win_small) |-> chr_a[BANK_W-2:0] == core_bank[BANK_W-2:0]);

  generate
    if (HAS_LATCH) begin : g_latch_chk
      // R8
      latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
        base_we |=> (!lat_big || chr_a[PPU_W+LATCH_W-1:PPU_W] == '0));

      // R7
      latch_load_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
        (cpu_we && cpu_a15 && !base_we) |=>
          (!lat_big || chr_a[PPU_W+LATCH_W-1:PPU_W] == $past(cpu_d[LATCH_W-1:0])));

      // R9
      ram_sel_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
        !chr_ram_sel);
    end else begin : g_nolatch_chk
      // R9
      ram_sel_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
        chr_ram_sel == mode_b5);
    end
  endgenerate

endmodule

bind chr_addr_composer chr_addr_composer_chk #(
  .BASE_W    (BASE_W),
  .BANK_W    (BANK_W),
  .LATCH_W   (LATCH_W),
  .PPU_W     (PPU_W),
  .HAS_LATCH (HAS_LATCH)
) u_chk (
  .clk            (clk),
  .rst_core_n     (rst_core_n),
  .mode_src_ppu   (mode_src_ppu),
  .mode_b5        (mode_b5),
  .mode_win_small (mode_win_small),
  .ppu_a          (ppu_a),
  .core_bank      (core_bank),
  .cpu_we         (cpu_we),
  .cpu_a15        (cpu_a15),
  .cpu_d          (cpu_d),
  .base_we        (base_we),
  .chr_a          (chr_a),
  .chr_ram_sel    (chr_ram_sel)
);

// File: tb/chr_addr_composer_tb.sv
module chr_addr_composer_tb;

  localparam int CLK_P    = 10;
  localparam int WD_LIMIT = 5000;
  localparam int NV       = 9;

  // {req[3:0], mode{src,b5,small}[2:0], base[7:0], latch[1:0], core[7:0], ppu[2:0], exp[10:0]}
  localparam logic [38:0] VEC [NV] = '{
    {4'd2, 3'b000, 8'hA5, 2'b11, 8'h3C, 3'b101, 11'b101_0011_1100},  // R2
    {4'd3, 3'b001, 8'hA5, 2'b00, 8'hFF, 3'b000, 11'b1010_1111111},   // R3
    {4'd4, 3'b100, 8'h5A, 2'b10, 8'hFF, 3'b011, 11'b010110_10_011},  // R4
    {4'd5, 3'b101, 8'h5A, 2'b11, 8'h00, 3'b110, 11'b0101101_1_110},  // R5
    {4'd6, 3'b110, 8'h5A, 2'b11, 8'hFF, 3'b001, 11'b01011010_001},   // R6
    {4'd6, 3'b111, 8'hC3, 2'b01, 8'h55, 3'b111, 11'b11000011_111},   // R6
    {4'd4, 3'b100, 8'hFF, 2'b01, 8'h00, 3'b000, 11'b111111_01_000},  // R4
    {4'd2, 3'b000, 8'h00, 2'b10, 8'h00, 3'b111, 11'b0},              // R2
    {4'd5, 3'b101, 8'h01, 2'b10, 8'hFF, 3'b010, 11'b0000000_0_010}   // R5
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_src_ppu, mode_b5, mode_win_small;
  logic [2:0]  ppu_a;
  logic [7:0]  core_bank;
  logic        cpu_we, cpu_a15, base_we;
  logic [7:0]  cpu_d;
  logic [10:0] chr_a, chr_a_nl;
  logic        ram_sel, ram_sel_nl;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  chr_addr_composer u_dut (
    .clk(clk), .rst_n(rst_n), .mode_src_ppu(mode_src_ppu), .mode_b5(mode_b5),
    .mode_win_small(mode_win_small), .ppu_a(ppu_a), .core_bank(core_bank),
    .cpu_we(cpu_we), .cpu_a15(cpu_a15), .cpu_d(cpu_d), .base_we(base_we),
    .chr_a(chr_a), .chr_ram_sel(ram_sel));

  chr_addr_composer #(.HAS_LATCH(1'b0)) u_dut_nl (
    .clk(clk), .rst_n(rst_n), .mode_src_ppu(mode_src_ppu), .mode_b5(mode_b5),
    .mode_win_small(mode_win_small), .ppu_a(ppu_a), .core_bank(core_bank),
    .cpu_we(cpu_we), .cpu_a15(cpu_a15), .cpu_d(cpu_d), .base_we(base_we),
    .chr_a(chr_a_nl), .chr_ram_sel(ram_sel_nl));

  task automatic check(input string req, input logic [10:0] got, input logic [10:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic write_base(input logic [7:0] d);
    @(negedge clk);
    base_we = 1'b1; cpu_d = d;
    @(negedge clk);
    base_we = 1'b0;
  endtask

  task automatic write_cpu(input logic a15, input logic [7:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_a15 = a15; cpu_d = d;
    @(negedge clk);
    cpu_we = 1'b0; cpu_a15 = 1'b0;
  endtask

  task automatic set_in(input logic [2:0] m, input logic [7:0] core, input logic [2:0] p);
    {mode_src_ppu, mode_b5, mode_win_small} = m;
    core_bank = core; ppu_a = p;
    #(CLK_P/4);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    rst_n = 1'b0; cpu_we = 1'b0; cpu_a15 = 1'b0; base_we = 1'b0; cpu_d = '0;
    mode_src_ppu = 1'b0; mode_b5 = 1'b0; mode_win_small = 1'b0;
    ppu_a = '0; core_bank = '0;
    do_reset();

    // R1: reset values of base and latch
    set_in(3'b100, 8'hFF, 3'b101);
    check("R1", chr_a, 11'b000000_00_101);
    set_in(3'b000, 8'h81, 3'b010);
    check("R1", chr_a, 11'h081);
    // R9: chr_ram_sel tied low with the latch built
    set_in(3'b110, 8'h00, 3'b000);
    check("R9", {10'b0, ram_sel}, 11'd0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [38:0] v;
      logic [10:0] exp_nl;
      v = VEC[i];
      write_base(v[31:24]);
      write_cpu(1'b1, {6'b101010, v[23:22]});
      @(negedge clk);
      set_in(v[34:32], v[21:14], v[13:11]);
      check($sformatf("R%0d", v[38:35]), chr_a, v[10:0]);
      // R9: the build without latch treats every PPU-sourced mode as fixed
      exp_nl = v[34] ? {v[31:24], v[13:11]} : v[10:0];
      check("R9", chr_a_nl, exp_nl);
      check("R9", {10'b0, ram_sel_nl}, {10'b0, v[33]});
    end

    // R2: ppu_a has no effect in banked mode
    write_base(8'hE0);
    set_in(3'b000, 8'h12, 3'b000);
    ppu_a = 3'b111; #(CLK_P/4);
    check("R2", chr_a, 11'b111_0001_0010);

    // R10: same-cycle response to core_bank and mode changes
    @(negedge clk);
    core_bank = 8'h34; #1;
    check("R10", chr_a, 11'b111_0011_0100);
    mode_src_ppu = 1'b1; mode_b5 = 1'b1; #1;
    check("R10", chr_a, 11'b11100000_111);

    // R7: write with A15 low is ignored, upper data bits ignored
    write_base(8'h00);
    write_cpu(1'b0, 8'h03);
    @(negedge clk);
    set_in(3'b100, 8'h00, 3'b000);
    check("R7", chr_a, 11'b000000_00_000);
    write_cpu(1'b1, 8'hFE);
    @(negedge clk);
    #(CLK_P/4);
    check("R7", chr_a, 11'b000000_10_000);

    // R8: base write clears latch
    write_base(8'h04);
    #(CLK_P/4);
    check("R8", chr_a, 11'b000001_00_000);

    // R8: base write wins over a same-cycle latch write
    write_cpu(1'b1, 8'h03);
    @(negedge clk);
    base_we = 1'b1; cpu_we = 1'b1; cpu_a15 = 1'b1; cpu_d = 8'h0B;
    @(negedge clk);
    base_we = 1'b0; cpu_we = 1'b0; cpu_a15 = 1'b0;
    #(CLK_P/4);
    check("R8", chr_a, 11'b000010_00_000);

    // R1: reset clears a loaded latch and base
    write_cpu(1'b1, 8'h03);
    do_reset();
    set_in(3'b100, 8'h00, 3'b001);
    check("R1", chr_a, 11'b000000_00_001);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule